// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block keeps an asynchronous page-mode DRAM array refreshed by issuing distributed refresh requests to a separate access sequencer. An interval timer, sized so that every row is visited once per retention period (32 ms normally, 128 ms for the extended-retention variant), adds one owed refresh per expiry. The sequencer sees a request while refreshes are owed, performs one refresh cycle per grant, and is warned through an urgency flag when the backlog grows. The refresh style input decides whether each refresh is a CAS-before-RAS cycle, which uses the device's own row counter, or a RAS-only cycle, for which this block supplies the row address from its own wrapping counter.

The block also manages a low-power hand-off. On a host request it asks the sequencer for a self-refresh entry cycle. It then keeps the sequencer in self-refresh for at least a minimum hold time, and after exit it keeps RAS high for a minimum recovery time. When the chosen style is distributed CAS-before-RAS, normal traffic resumes at once. For RAS-only or burst styles, the block first requests one refresh for every row and only then releases traffic.

The controller has five named states. ST_RUN is normal distributed refresh. ST_SR_ENTER waits for the grant of the entry cycle. ST_SR_HOLD covers the self-refresh residency. ST_SR_EXIT covers RAS-high recovery. ST_CATCHUP issues the full-array burst. The transitions are:
- run-to-enter on `sr_enter_req`.
- enter-to-hold on the entry grant.
- hold-to-exit once the hold minimum has elapsed and `sr_exit_req` is high.
- exit-to-run for the distributed CBR style, or exit-to-catchup for any other style, once the recovery minimum has elapsed.
- catchup-to-run on the grant of the last row.

Top module: `rfsh_sched`

## Requirements
- R1: While `rst_n` is low, `rq_valid`, `urgent`, `sr_hold` and `traffic_hold` are 0, and `owed_count` and `rq_row` are 0.
- R2: In ST_RUN the timer reload is RELOAD = CLK_HZ × P / (1000 × ROWS) clocks. P is 32 ms when EXT_RETENTION = 0 and 128 ms otherwise. The first owed refresh appears RELOAD clock edges after reset release, and another follows every RELOAD edges.
- R3: `owed_count` saturates at PEND_MAX. A timer expiry and an accepted grant in the same cycle leave it unchanged.
- R4: `urgent` is 1 exactly when `owed_count` ≥ URG_THR.
- R5: In ST_RUN, `rq_valid` = (`owed_count` ≠ 0). A grant decrements the count. A grant while the count is 0 changes neither the count nor `rq_row`.
- R6: `rq_kind` encodes 2'b00 = CAS-before-RAS, 2'b01 = RAS-only, 2'b10 = self-refresh entry. `style_sel` encodes 2'b00 = distributed CBR, 2'b01 = RAS-only, 2'b10/2'b11 = burst CBR. Normal and catch-up requests are RAS-only only when the style is 2'b01.
- R7: `rq_row` advances by one only on a granted RAS-only request, and wraps from ROWS−1 to 0.
- R8: `sr_enter_req` in ST_RUN leads to an entry request (`rq_valid` = 1, kind 2'b10, `traffic_hold` = 1). Its grant clears `owed_count`, raises `sr_hold` and drops `rq_valid`.
- R9: `sr_hold` stays high for at least HOLD_MIN_CYC cycles, and for exactly HOLD_MIN_CYC cycles when `sr_exit_req` is already high.
- R10: After `sr_hold` falls, there are exactly EXIT_MIN_CYC cycles with `traffic_hold` = 1 and no request.
- R11: With style 2'b00, the block returns directly to ST_RUN with `owed_count` = 0 and the timer restarted from its full reload value.
- R12: With any other style, exactly ROWS catch-up requests are issued under `traffic_hold`, with kind per R6 and rows per R7. The block then returns to ST_RUN with `owed_count` = 0 and the timer restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| style_sel | input | 2 | Refresh style (R6 encoding) |
| sr_enter_req | input | 1 | Host asks for self-refresh |
| sr_exit_req | input | 1 | Host allows self-refresh exit |
| rq_grant | input | 1 | Sequencer performed the requested cycle |
| rq_valid | output | 1 | Refresh or entry cycle requested |
| rq_kind | output | 2 | Kind of requested cycle |
| rq_row | output | $clog2(ROWS) | Row address for RAS-only refresh |
| owed_count | output | $clog2(PEND_MAX+1) | Refreshes owed |
| urgent | output | 1 | Backlog reached threshold |
| sr_hold | output | 1 | Keep device in self-refresh (RAS low) |
| traffic_hold | output | 1 | Normal traffic must not be issued |

## Verification
The bench builds the block with CLK_HZ = 8000, ROWS = 16, PEND_MAX = 8, URG_THR = 6, HOLD_MIN_CYC = 5 and EXIT_MIN_CYC = 3. It adds a second instance with EXT_RETENTION = 1, so the reload values are 16 and 64 clocks. These small values bring saturation, the urgency threshold, row wrap and a full-array catch-up within a few hundred cycles. A cycle-by-cycle arithmetic model is therefore checked against every output, under grant patterns in all three styles and through the self-refresh sequence in each style.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_SR_ENTER = 3'd1,
        ST_SR_HOLD  = 3'd2,
        ST_SR_EXIT  = 3'd3,
        ST_CATCHUP  = 3'd4
    } rfsh_state_e;

    localparam logic [1:0] RK_CBR  = 2'b00;
    localparam logic [1:0] RK_RAS  = 2'b01;
    localparam logic [1:0] RK_SELF = 2'b10;

    localparam logic [1:0] STY_CBR_DIST = 2'b00;
    localparam logic [1:0] STY_RAS_ONLY = 2'b01;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int RELOAD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(RELOAD + 1);
    localparam logic [TW-1:0] RLD = TW'(RELOAD);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RLD;
        end else if (!run || cnt_q == ONE) begin
            cnt_q <= RLD;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign tick = run && (cnt_q == ONE);

endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
    parameter int PEND_MAX = 8,
    parameter int URG_THR  = 6,
    localparam int PW      = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          clr,
    output logic [PW-1:0] count,
    output logic          urgent
);
    localparam logic [PW-1:0] MAXV = PW'(PEND_MAX);
    localparam logic [PW-1:0] THR  = PW'(URG_THR);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] cnt_d;
    logic          dec_ok;

    assign dec_ok = dec && (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !dec_ok) begin
            if (cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
        end else if (!inc && dec_ok) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count  = cnt_q;
    assign urgent = (cnt_q >= THR);

endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int ROWS = 2048,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [RW-1:0] row
);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    logic [RW-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (advance) begin
            row_q <= (row_q == LAST) ? '0 : row_q + 1'b1;
        end
    end

    assign row = row_q;

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int CLK_HZ        = 100_000_000,
    parameter int ROWS          = 2048,
    parameter int EXT_RETENTION = 0,
    parameter int PEND_MAX      = 8,
    parameter int URG_THR       = 6,
    parameter int HOLD_MIN_CYC  = 10_000,
    parameter int EXIT_MIN_CYC  = 11_000,
    localparam int ROW_W        = $clog2(ROWS),
    localparam int PW           = $clog2(PEND_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       style_sel,
    input  logic             sr_enter_req,
    input  logic             sr_exit_req,
    input  logic             rq_grant,
    output logic             rq_valid,
    output logic [1:0]       rq_kind,
    output logic [ROW_W-1:0] rq_row,
    output logic [PW-1:0]    owed_count,
    output logic             urgent,
    output logic             sr_hold,
    output logic             traffic_hold
);
    // Interval derivation: retention period spread evenly over all rows.
    localparam int     PERIOD_MS  = (EXT_RETENTION != 0) ? 128 : 32;
    localparam longint PERIOD_CYC = longint'(CLK_HZ) * longint'(PERIOD_MS) / longint'(1000);
    localparam int     RELOAD_RAW = int'(PERIOD_CYC / longint'(ROWS));
    localparam int     RELOAD     = (RELOAD_RAW < 1) ? 1 : RELOAD_RAW;

    // One wait counter serves hold, exit recovery and catch-up.
    localparam int MAX_A    = (HOLD_MIN_CYC > EXIT_MIN_CYC) ? HOLD_MIN_CYC : EXIT_MIN_CYC;
    localparam int WAIT_MAX = (MAX_A > ROWS) ? MAX_A : ROWS;
    localparam int CW       = $clog2(WAIT_MAX + 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_MIN_CYC - 1);
    localparam logic [CW-1:0] EXIT_LD = CW'(EXIT_MIN_CYC - 1);
    localparam logic [CW-1:0] CU_LD   = CW'(ROWS - 1);

    rfsh_state_e   state_q, state_d;
    logic [CW-1:0] wait_q, wait_d;

    logic          timer_run;
    logic          tick;
    logic          owed_dec;
    logic          owed_clr;
    logic          row_adv;
    logic          ras_style;

    assign ras_style = (style_sel == STY_RAS_ONLY);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        unique case (state_q)
            ST_RUN: begin
                if (sr_enter_req) state_d = ST_SR_ENTER;
            end
            ST_SR_ENTER: begin
                if (rq_grant) begin
                    state_d = ST_SR_HOLD;
                    wait_d  = HOLD_LD;
                end
            end
            ST_SR_HOLD: begin
                if (wait_q != '0) begin
                    wait_d = wait_q - 1'b1;
                end else if (sr_exit_req) begin
                    state_d = ST_SR_EXIT;
                    wait_d  = EXIT_LD;
                end
            end
            ST_SR_EXIT: begin
                if (wait_q != '0) begin
                    wait_d = wait_q - 1'b1;
                end else if (style_sel == STY_CBR_DIST) begin
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_CATCHUP;
                    wait_d  = CU_LD;
                end
            end
            ST_CATCHUP: begin
                if (rq_grant) begin
                    if (wait_q == '0) state_d = ST_RUN;
                    else              wait_d  = wait_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
        end
    end

    // Outputs and sub-block controls
    always_comb begin
        rq_valid     = 1'b0;
        rq_kind      = RK_CBR;
        sr_hold      = 1'b0;
        traffic_hold = 1'b1;
        timer_run    = 1'b0;
        owed_dec     = 1'b0;
        owed_clr     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                traffic_hold = 1'b0;
                timer_run    = 1'b1;
                rq_valid     = (owed_count != '0);
                rq_kind      = ras_style ? RK_RAS : RK_CBR;
                owed_dec     = rq_grant;
            end
            ST_SR_ENTER: begin
                timer_run = 1'b1;
                rq_valid  = 1'b1;
                rq_kind   = RK_SELF;
                owed_clr  = rq_grant;
            end
            ST_SR_HOLD: begin
                sr_hold = 1'b1;
            end
            ST_SR_EXIT: begin
                sr_hold = 1'b0;
            end
            ST_CATCHUP: begin
                rq_valid = 1'b1;
                rq_kind  = ras_style ? RK_RAS : RK_CBR;
            end
            default: begin
                traffic_hold = 1'b1;
            end
        endcase
    end

    assign row_adv = rq_valid && rq_grant && (rq_kind == RK_RAS);

    rfsh_interval_timer #(
        .RELOAD(RELOAD)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    rfsh_owed_counter #(
        .PEND_MAX(PEND_MAX),
        .URG_THR (URG_THR)
    ) owed_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (tick),
        .dec    (owed_dec),
        .clr    (owed_clr),
        .count  (owed_count),
        .urgent (urgent)
    );

    rfsh_row_counter #(
        .ROWS(ROWS)
    ) row_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (row_adv),
        .row     (rq_row)
    );

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int ROWS         = 2048,
    parameter int PEND_MAX     = 8,
    parameter int HOLD_MIN_CYC = 10_000,
    localparam int RW          = $clog2(ROWS),
    localparam int PW          = $clog2(PEND_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rq_grant,
    input logic          rq_valid,
    input logic [1:0]    rq_kind,
    input logic [RW-1:0] rq_row,
    input logic [PW-1:0] owed_count,
    input logic          urgent,
    input logic          sr_hold,
    input logic          traffic_hold
);
    logic [31:0] hold_run;

    always_ff @(posedge clk) begin
        if (!rst_n)       hold_run <= '0;
        else if (sr_hold) hold_run <= (hold_run == 32'hFFFF_FFFF) ? hold_run : hold_run + 1;
        else              hold_run <= '0;
    end

    // R3
    owed_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed_count <= PW'(PEND_MAX));

    // R4
    urgent_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> rq_valid);

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rq_grant && rq_kind == 2'b01) |=>
        rq_row == (($past(rq_row) == RW'(ROWS - 1)) ? '0 : $past(rq_row) + 1'b1));

    // R7
    row_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rq_valid && rq_grant && rq_kind == 2'b01) |=> $stable(rq_row));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_hold |-> (!rq_valid && traffic_hold && owed_count == '0));

    // R9
    hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_hold) |-> (hold_run >= 32'(HOLD_MIN_CYC)));

    // R10
    exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_hold) |-> (!rq_valid && traffic_hold));

    // R6
    self_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rq_kind == 2'b10) |-> (traffic_hold && !sr_hold));

endmodule

bind rfsh_sched rfsh_sched_chk #(
    .ROWS        (ROWS),
    .PEND_MAX    (PEND_MAX),
    .HOLD_MIN_CYC(HOLD_MIN_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rq_grant    (rq_grant),
    .rq_valid    (rq_valid),
    .rq_kind     (rq_kind),
    .rq_row      (rq_row),
    .owed_count  (owed_count),
    .urgent      (urgent),
    .sr_hold     (sr_hold),
    .traffic_hold(traffic_hold)
);

// File: tb/rfsh_sched_tb_top.sv
module rfsh_sched_tb_top;

    localparam int CLK_HZ  = 8000;
    localparam int ROWS    = 16;
    localparam int PMAX    = 8;
    localparam int UTHR    = 6;
    localparam int HOLDC   = 5;
    localparam int EXITC   = 3;
    localparam int RLD     = 16;   // 8000*32/1000/16
    localparam int RLD_EXT = 64;   // 8000*128/1000/16

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] style_sel = 2'b00;
    logic       sr_enter_req = 1'b0;
    logic       sr_exit_req = 1'b0;
    logic       rq_grant = 1'b0;

    logic       rq_valid, urgent, sr_hold, traffic_hold;
    logic [1:0] rq_kind;
    logic [3:0] rq_row;
    logic [3:0] owed_count;

    logic       x_valid, x_urgent, x_hold, x_traffic;
    logic [1:0] x_kind;
    logic [3:0] x_row;
    logic [3:0] x_owed;

    int n_checks = 0;
    int n_fail   = 0;

    int m_owed = 0;
    int m_row  = 0;
    int m_n    = 0;

    always #5 clk = ~clk;

    rfsh_sched #(
        .CLK_HZ(CLK_HZ), .ROWS(ROWS), .EXT_RETENTION(0), .PEND_MAX(PMAX),
        .URG_THR(UTHR), .HOLD_MIN_CYC(HOLDC), .EXIT_MIN_CYC(EXITC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .style_sel(style_sel),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req), .rq_grant(rq_grant),
        .rq_valid(rq_valid), .rq_kind(rq_kind), .rq_row(rq_row),
        .owed_count(owed_count), .urgent(urgent), .sr_hold(sr_hold),
        .traffic_hold(traffic_hold)
    );

    rfsh_sched #(
        .CLK_HZ(CLK_HZ), .ROWS(ROWS), .EXT_RETENTION(1), .PEND_MAX(PMAX),
        .URG_THR(UTHR), .HOLD_MIN_CYC(HOLDC), .EXIT_MIN_CYC(EXITC)
    ) dut_ext_i (
        .clk(clk), .rst_n(rst_n), .style_sel(style_sel),
        .sr_enter_req(1'b0), .sr_exit_req(1'b0), .rq_grant(1'b0),
        .rq_valid(x_valid), .rq_kind(x_kind), .rq_row(x_row),
        .owed_count(x_owed), .urgent(x_urgent), .sr_hold(x_hold),
        .traffic_hold(x_traffic)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_edge();
        @(posedge clk);
        #1;
    endtask

    // One normal-mode cycle: drive grant, advance, update model, compare.
    task automatic step(input logic g);
        bit gg;
        rq_grant = g;
        tick_edge();
        m_n++;
        gg = g && (m_owed > 0);
        if (gg && style_sel == 2'b01) m_row = (m_row + 1) % ROWS;
        m_owed = m_owed + ((m_n % RLD == 0) ? 1 : 0) - (gg ? 1 : 0);
        if (m_owed > PMAX) m_owed = PMAX;
        check("R3 owed", int'(owed_count), m_owed);
        check("R4 urgent", int'(urgent), (m_owed >= UTHR) ? 1 : 0);
        check("R5 valid", int'(rq_valid), (m_owed != 0) ? 1 : 0);
        check("R6 kind", int'(rq_kind), (style_sel == 2'b01) ? 1 : 0);
        check("R7 row", int'(rq_row), m_row);
    endtask

    task automatic pattern(input int cycles, input int seed);
        logic [7:0] lf;
        lf = 8'(seed) | 8'h01;
        for (int i = 0; i < cycles; i++) begin
            int seg;
            logic g;
            seg = i / 100;
            case (seg % 3)
                0: style_sel = 2'b00;
                1: style_sel = 2'b01;
                default: style_sel = 2'b10;
            endcase
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            g = (seg % 2 == 0) ? (lf[2:0] == 3'b000) : (lf[4:0] == 5'b00000);
            step(g);
        end
        rq_grant = 1'b0;
    endtask

    task automatic sr_cycle(input logic [1:0] sty);
        int cnt;
        style_sel    = sty;
        rq_grant     = 1'b0;
        sr_enter_req = 1'b1;
        tick_edge();
        sr_enter_req = 1'b0;
        check("R8 entry valid", int'(rq_valid), 1);
        check("R8 entry kind", int'(rq_kind), 2);
        check("R8 entry traffic_hold", int'(traffic_hold), 1);
        check("R8 entry sr_hold", int'(sr_hold), 0);
        tick_edge();
        check("R8 entry waits for grant", int'(rq_valid), 1);
        sr_exit_req = 1'b1;
        rq_grant    = 1'b1;
        tick_edge();
        rq_grant = 1'b0;
        check("R8 hold after grant", int'(sr_hold), 1);
        check("R8 owed cleared", int'(owed_count), 0);
        check("R8 no request in hold", int'(rq_valid), 0);
        cnt = 0;
        while (sr_hold && cnt < 100) begin
            cnt++;
            tick_edge();
        end
        check("R9 hold cycles", cnt, HOLDC);
        cnt = 0;
        while (traffic_hold && !rq_valid && !sr_hold && cnt < 100) begin
            cnt++;
            tick_edge();
        end
        check("R10 exit wait cycles", cnt, EXITC);
        sr_exit_req = 1'b0;
        m_n    = 0;
        m_owed = 0;
        if (sty == 2'b00) begin
            check("R11 traffic released", int'(traffic_hold), 0);
            check("R11 owed zero", int'(owed_count), 0);
            check("R11 no request", int'(rq_valid), 0);
        end else begin
            check("R12 catchup valid", int'(rq_valid), 1);
            check("R12 catchup kind", int'(rq_kind), (sty == 2'b01) ? 1 : 0);
            rq_grant = 1'b1;
            cnt = 0;
            while (traffic_hold && cnt < 100) begin
                check("R12 catchup row", int'(rq_row), m_row);
                cnt++;
                tick_edge();
                if (sty == 2'b01) m_row = (m_row + 1) % ROWS;
            end
            rq_grant = 1'b0;
            check("R12 catchup count", cnt, ROWS);
            check("R12 owed zero after", int'(owed_count), 0);
            check("R12 row after catchup", int'(rq_row), m_row);
            m_n = 0;
        end
    endtask

    initial begin
        repeat (3) tick_edge();
        // R1
        check("R1 valid", int'(rq_valid), 0);
        check("R1 urgent", int'(urgent), 0);
        check("R1 sr_hold", int'(sr_hold), 0);
        check("R1 traffic_hold", int'(traffic_hold), 0);
        check("R1 owed", int'(owed_count), 0);
        check("R1 row", int'(rq_row), 0);
        rst_n = 1'b1;
        m_n = 0; m_owed = 0; m_row = 0;
        // R2 interval sweep, both retention variants, through saturation
        for (int i = 0; i < 10 * RLD; i++) begin
            int xe;
            step(1'b0);
            xe = m_n / RLD_EXT;
            if (xe > PMAX) xe = PMAX;
            check("R2 extended interval", int'(x_owed), xe);
            if (m_n == RLD - 1) check("R2 no tick before reload", int'(owed_count), 0);
            if (m_n == RLD)     check("R2 first tick", int'(owed_count), 1);
        end
        pattern(600, 8'h5A);
        sr_cycle(2'b00);
        style_sel = 2'b00;
        for (int i = 0; i < 40; i++) step(1'b0);
        sr_cycle(2'b01);
        style_sel = 2'b01;
        for (int i = 0; i < 40; i++) step(1'b0);
        sr_cycle(2'b10);
        style_sel = 2'b10;
        for (int i = 0; i < 40; i++) step(1'b0);
        pattern(300, 8'hC3);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule